// File: doc/BRIEF.md
# Single-Wire Slave Bus Timing Front-End

This block sits on the slave side of a single open-drain serial line and turns the line's waveform into events for an upper protocol layer. It watches the synchronized line level, measures every low pulse, and decides whether the pulse is a bus reset, the start of a one-bit time slot, or a stray pulse to be discarded. After a valid reset it answers with a presence pulse. In a write slot it samples the master's bit. In a read slot it pulls the line low for a defined window when the supplied bit is 0.

The block keeps a two-level speed state, standard or fast. The upper layer requests fast timing with a one-cycle strobe, and the switch happens when the next slot ends. A long reset always returns the block to standard timing. A shorter reset window is accepted only while fast timing is active, and that reset keeps fast timing. All durations are microsecond parameters scaled by a cycles-per-microsecond parameter. Command decoding, identity storage and checksums belong to the upper layer.

Top module: `sw_slave_front`

## Requirements
- R1: From reset, `lineDriveLow` and `fastMode` are 0. No strobe fires and low pulses are not treated as slots until the first bus reset has been recognised.
- R2: When the line rises after a low of at least `RST_US` microseconds, `resetSeen` pulses for one cycle and `fastMode` becomes 0. This applies at either speed.
- R3: After a recognised reset, the block waits the presence-high delay counted from the line's rise (`PDH_STD_US` or `PDH_FAST_US`), then drives the line low for the presence-low time (`PDL_STD_US` or `PDL_FAST_US`). `lineDriveLow` rises `delay+1` cycles after the master releases the line.
- R4: In a write slot, the line is sampled `SMP_STD_US` (or `SMP_FAST_US`) after the falling edge. A high level gives one `rxValid` pulse with `rxBit`=1 at once. A low level gives one pulse with `rxBit`=0 when the line rises, but only if the low lasted no longer than the slot limit.
- R5: A slot whose falling edge sees `txEn`=1 is a read slot. It pulses `bitReq` once and gives no `rxValid`. If `txBit`=0, `lineDriveLow` is held for exactly the sample time from the fall. If `txBit`=1, the line is not driven.
- R6: A low longer than the slot limit (`SLOT_STD_US` / `SLOT_FAST_US`) that is not a reset produces no strobe. The next slot after it is decoded normally.
- R7: After each slot or presence pulse, the line must stay high for the recovery time (`REC_STD_US` / `REC_FAST_US`). A low pulse that starts earlier produces no slot strobe.
- R8: While `fastMode`=1, a low between `FRST_MIN_US` and `FRST_MAX_US` inclusive is a reset that keeps `fastMode`=1. A low between `FRST_MAX_US` and `RST_US` is ignored.
- R9: A one-cycle `setFast` pulse does not change `fastMode` right away. `fastMode` becomes 1 at the end of the next completed slot.
- R10: With `fastMode`=1, slot sampling, read drive length, slot limit, recovery and presence all use the fast parameters.
- R11: `lineDriveLow` is asserted only during a presence-low phase or during a read-0 slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Synchronized line level, 1 = high |
| txEn | input | 1 | Next slot is a read slot |
| txBit | input | 1 | Bit to send in a read slot |
| setFast | input | 1 | Request fast timing from the end of the next slot |
| lineDriveLow | output | 1 | 1 = pull the line low |
| fastMode | output | 1 | Current speed, 1 = fast |
| resetSeen | output | 1 | One-cycle strobe on a recognised reset |
| rxValid | output | 1 | One-cycle strobe with a received bit |
| rxBit | output | 1 | Last received bit |
| bitReq | output | 1 | One-cycle strobe when a read slot starts |

## Verification
The hardest case to reach is a reset of intermediate length. It must count as a reset only while fast timing is active, and it must be ignored at standard speed or when it runs past the fast window. To get there, the stimulus first promotes the block with `setFast` and one standard slot, then runs fast slots, a fast-window reset, an over-window low and a fast read. Last it sends a long reset to confirm the fall back to standard presence timing. A separate directed case starts a new low pulse two cycles after a slot ends, inside the recovery window, and expects no strobe.

// File: rtl/sw_slave_pkg.sv
package sw_slave_pkg;

  typedef enum logic [2:0] {
    ST_WAITRST,
    ST_IDLE,
    ST_SLOT,
    ST_TAIL,
    ST_SKIP,
    ST_RECOVER,
    ST_PDH,
    ST_PDL
  } sw_state_e;

  typedef struct packed {
    logic phaseClr;
    logic driveSet;
    logic driveClr;
    logic rxLd;
    logic rxVal;
  } dp_ctl_t;

endpackage

// File: rtl/sw_slave_dp.sv
module sw_slave_dp
  import sw_slave_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lineIn,
  input  dp_ctl_t          ctl,
  output logic             rose,
  output logic             fell,
  output logic [CNT_W-1:0] lowLen,
  output logic [CNT_W-1:0] phase,
  output logic             drive,
  output logic             rxBit
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic lineQ;

  assign rose = lineIn & ~lineQ;
  assign fell = ~lineIn & lineQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineQ <= 1'b1;
      lowLen <= '0;
    end else begin
      lineQ <= lineIn;
      if (lineIn) lowLen <= '0;
      else if (lowLen != CNT_MAX) lowLen <= lowLen + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else if (ctl.phaseClr) phase <= '0;
    else if (phase != CNT_MAX) phase <= phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive <= 1'b0;
      rxBit <= 1'b0;
    end else begin
      if (ctl.driveSet) drive <= 1'b1;
      else if (ctl.driveClr) drive <= 1'b0;
      if (ctl.rxLd) rxBit <= ctl.rxVal;
    end
  end

endmodule

// File: rtl/sw_slave_ctl.sv
module sw_slave_ctl
  import sw_slave_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int RST_C       = 1920,
  parameter int FRST_MIN_C  = 192,
  parameter int FRST_MAX_C  = 320,
  parameter int PDH_STD_C   = 120,
  parameter int PDL_STD_C   = 480,
  parameter int PDH_FAST_C  = 16,
  parameter int PDL_FAST_C  = 64,
  parameter int SMP_STD_C   = 120,
  parameter int SMP_FAST_C  = 12,
  parameter int SLOT_STD_C  = 480,
  parameter int SLOT_FAST_C = 64,
  parameter int REC_STD_C   = 20,
  parameter int REC_FAST_C  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lineIn,
  input  logic             rose,
  input  logic             fell,
  input  logic [CNT_W-1:0] lowLen,
  input  logic [CNT_W-1:0] phase,
  input  logic             txEn,
  input  logic             txBit,
  input  logic             setFast,
  output dp_ctl_t          ctl,
  output logic             fastMode,
  output logic             resetSeen,
  output logic             rxValid,
  output logic             bitReq
);

  localparam logic [CNT_W-1:0] RST_L   = CNT_W'(RST_C);
  localparam logic [CNT_W-1:0] FMIN_L  = CNT_W'(FRST_MIN_C);
  localparam logic [CNT_W-1:0] FMAX_L  = CNT_W'(FRST_MAX_C);

  sw_state_e state, nxtState;
  logic isRead, nxtRead, pendFast;
  logic stdRst, fastRst, takeRst;
  logic rxPulse, reqPulse, slotDone;
  logic [CNT_W-1:0] smpLim, slotLim, recLim, pdhLim, pdlLim;

  // speed-dependent limits, expressed as last phase value of each window
  always_comb begin
    smpLim  = fastMode ? CNT_W'(SMP_FAST_C - 1)  : CNT_W'(SMP_STD_C - 1);
    slotLim = fastMode ? CNT_W'(SLOT_FAST_C)     : CNT_W'(SLOT_STD_C);
    recLim  = fastMode ? CNT_W'(REC_FAST_C - 1)  : CNT_W'(REC_STD_C - 1);
    pdhLim  = fastMode ? CNT_W'(PDH_FAST_C - 1)  : CNT_W'(PDH_STD_C - 1);
    pdlLim  = fastMode ? CNT_W'(PDL_FAST_C - 1)  : CNT_W'(PDL_STD_C - 1);
  end

  assign stdRst  = rose && (lowLen >= RST_L);
  assign fastRst = rose && fastMode && (lowLen >= FMIN_L) && (lowLen <= FMAX_L);
  assign takeRst = (stdRst || fastRst) && (state != ST_PDH) && (state != ST_PDL);

  always_comb begin
    nxtState = state;
    nxtRead  = isRead;
    ctl      = '0;
    rxPulse  = 1'b0;
    reqPulse = 1'b0;
    slotDone = 1'b0;
    if (takeRst) begin
      nxtState     = ST_PDH;
      ctl.phaseClr = 1'b1;
      ctl.driveClr = 1'b1;
    end else begin
      unique case (state)
        ST_WAITRST: ;
        ST_IDLE: if (fell) begin
          ctl.phaseClr = 1'b1;
          nxtState     = ST_SLOT;
          nxtRead      = txEn;
          reqPulse     = txEn;
          ctl.driveSet = txEn && !txBit;
        end
        ST_SLOT: if (phase == smpLim) begin
          ctl.driveClr = 1'b1;
          if (lineIn) begin
            slotDone     = 1'b1;
            rxPulse      = !isRead;
            ctl.rxLd     = !isRead;
            ctl.rxVal    = 1'b1;
            ctl.phaseClr = 1'b1;
            nxtState     = ST_RECOVER;
          end else begin
            nxtState = ST_TAIL;
          end
        end
        ST_TAIL: if (rose) begin
          ctl.phaseClr = 1'b1;
          nxtState     = ST_RECOVER;
          if (lowLen <= slotLim) begin
            slotDone  = 1'b1;
            rxPulse   = !isRead;
            ctl.rxLd  = !isRead;
            ctl.rxVal = 1'b0;
          end
        end
        ST_SKIP: if (rose) begin
          ctl.phaseClr = 1'b1;
          nxtState     = ST_RECOVER;
        end
        ST_RECOVER: begin
          if (fell) nxtState = ST_SKIP;
          else if (phase >= recLim) nxtState = ST_IDLE;
        end
        ST_PDH: if (phase == pdhLim) begin
          ctl.driveSet = 1'b1;
          ctl.phaseClr = 1'b1;
          nxtState     = ST_PDL;
        end
        ST_PDL: if (phase == pdlLim) begin
          ctl.driveClr = 1'b1;
          ctl.phaseClr = 1'b1;
          nxtState     = ST_RECOVER;
        end
        default: nxtState = ST_WAITRST;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_WAITRST;
      isRead    <= 1'b0;
      resetSeen <= 1'b0;
      rxValid   <= 1'b0;
      bitReq    <= 1'b0;
    end else begin
      state     <= nxtState;
      isRead    <= nxtRead;
      resetSeen <= takeRst;
      rxValid   <= rxPulse;
      bitReq    <= reqPulse;
    end
  end

  // speed state: long reset clears, pending request lands at slot end
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fastMode <= 1'b0;
      pendFast <= 1'b0;
    end else if (takeRst && stdRst) begin
      fastMode <= 1'b0;
      pendFast <= 1'b0;
    end else begin
      if (slotDone && pendFast) fastMode <= 1'b1;
      if (setFast) pendFast <= 1'b1;
      else if (slotDone) pendFast <= 1'b0;
    end
  end

  p_quiet_before_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAITRST && $past(state) == ST_WAITRST) |-> (!rxValid && !bitReq));

  p_rx_from_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |-> ($past(state) == ST_SLOT || $past(state) == ST_TAIL));

  p_presence_follows_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    resetSeen |-> (state == ST_PDH));

  p_fast_at_slot_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fastMode) |-> $past(slotDone));

  p_fast_reset_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (resetSeen && $past(fastMode) && $past(lowLen) <= FMAX_L) |-> fastMode);

endmodule

// File: rtl/sw_slave_front.sv
module sw_slave_front
  import sw_slave_pkg::*;
#(
  parameter int US_CYC       = 4,
  parameter int RST_US       = 480,
  parameter int FRST_MIN_US  = 48,
  parameter int FRST_MAX_US  = 80,
  parameter int PDH_STD_US   = 30,
  parameter int PDL_STD_US   = 120,
  parameter int PDH_FAST_US  = 4,
  parameter int PDL_FAST_US  = 16,
  parameter int SMP_STD_US   = 30,
  parameter int SMP_FAST_US  = 3,
  parameter int SLOT_STD_US  = 120,
  parameter int SLOT_FAST_US = 16,
  parameter int REC_STD_US   = 5,
  parameter int REC_FAST_US  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lineIn,
  input  logic txEn,
  input  logic txBit,
  input  logic setFast,
  output logic lineDriveLow,
  output logic fastMode,
  output logic resetSeen,
  output logic rxValid,
  output logic rxBit,
  output logic bitReq
);

  localparam int RST_C = RST_US * US_CYC;
  localparam int CNT_W = $clog2(RST_C + 2) + 1;

  dp_ctl_t ctl;
  logic rose, fell;
  logic [CNT_W-1:0] lowLen, phase;

  sw_slave_ctl #(
    .CNT_W(CNT_W), .RST_C(RST_C),
    .FRST_MIN_C(FRST_MIN_US * US_CYC), .FRST_MAX_C(FRST_MAX_US * US_CYC),
    .PDH_STD_C(PDH_STD_US * US_CYC), .PDL_STD_C(PDL_STD_US * US_CYC),
    .PDH_FAST_C(PDH_FAST_US * US_CYC), .PDL_FAST_C(PDL_FAST_US * US_CYC),
    .SMP_STD_C(SMP_STD_US * US_CYC), .SMP_FAST_C(SMP_FAST_US * US_CYC),
    .SLOT_STD_C(SLOT_STD_US * US_CYC), .SLOT_FAST_C(SLOT_FAST_US * US_CYC),
    .REC_STD_C(REC_STD_US * US_CYC), .REC_FAST_C(REC_FAST_US * US_CYC)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .lineIn(lineIn), .rose(rose), .fell(fell),
    .lowLen(lowLen), .phase(phase), .txEn(txEn), .txBit(txBit),
    .setFast(setFast), .ctl(ctl), .fastMode(fastMode),
    .resetSeen(resetSeen), .rxValid(rxValid), .bitReq(bitReq)
  );

  sw_slave_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .lineIn(lineIn), .ctl(ctl),
    .rose(rose), .fell(fell), .lowLen(lowLen), .phase(phase),
    .drive(lineDriveLow), .rxBit(rxBit)
  );

  // drive only in presence-low or a read-0 slot
  p_drive_context_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lineDriveLow) |-> ($past(u_ctl.state) == ST_PDH ||
                             ($past(u_ctl.state) == ST_IDLE && $past(txEn) && !$past(txBit))));

endmodule

// File: tb/sw_slave_front_tb.sv
module sw_slave_front_tb;

  localparam int PDH_S = 30, PDL_S = 120, PDH_F = 4, PDL_F = 16;

  typedef struct packed {
    logic       setf;
    logic       txEn;
    logic       txBit;
    logic [9:0] lowLen;
    logic [1:0] expRx;    // 0/1 = bit expected, 2 = no rxValid
    logic       expPres;
    logic       expFast;
    logic [7:0] expDrv;   // drive pulse length, 0 = none
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 10'd500, 2'd2, 1'b1, 1'b0, 8'd120, 4'd2},  // R2 R3 std reset
    '{1'b0, 1'b0, 1'b0, 10'd60,  2'd0, 1'b0, 1'b0, 8'd0,   4'd4},  // R4 write 0
    '{1'b0, 1'b0, 1'b0, 10'd6,   2'd1, 1'b0, 1'b0, 8'd0,   4'd4},  // R4 write 1
    '{1'b0, 1'b1, 1'b0, 10'd2,   2'd2, 1'b0, 1'b0, 8'd30,  4'd5},  // R5 read 0
    '{1'b0, 1'b1, 1'b1, 10'd2,   2'd2, 1'b0, 1'b0, 8'd0,   4'd5},  // R5 read 1
    '{1'b0, 1'b0, 1'b0, 10'd200, 2'd2, 1'b0, 1'b0, 8'd0,   4'd6},  // R6 ignored low
    '{1'b0, 1'b0, 1'b0, 10'd6,   2'd1, 1'b0, 1'b0, 8'd0,   4'd6},  // R6 resync
    '{1'b1, 1'b0, 1'b0, 10'd60,  2'd0, 1'b0, 1'b1, 8'd0,   4'd9},  // R9 go fast
    '{1'b0, 1'b0, 1'b0, 10'd10,  2'd0, 1'b0, 1'b1, 8'd0,   4'd10}, // R10 fast w0
    '{1'b0, 1'b0, 1'b0, 10'd1,   2'd1, 1'b0, 1'b1, 8'd0,   4'd10}, // R10 fast w1
    '{1'b0, 1'b0, 1'b0, 10'd60,  2'd2, 1'b1, 1'b1, 8'd16,  4'd8},  // R8 fast reset
    '{1'b0, 1'b0, 1'b0, 10'd200, 2'd2, 1'b0, 1'b1, 8'd0,   4'd8},  // R8 over window
    '{1'b0, 1'b1, 1'b0, 10'd1,   2'd2, 1'b0, 1'b1, 8'd3,   4'd10}, // R10 fast read0
    '{1'b0, 1'b0, 1'b0, 10'd500, 2'd2, 1'b1, 1'b0, 8'd120, 4'd2},  // R2 back to std
    '{1'b0, 1'b0, 1'b0, 10'd60,  2'd0, 1'b0, 1'b0, 8'd0,   4'd4}   // R4 std again
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic mLow = 1'b0, txEn = 1'b0, txBit = 1'b0, setFast = 1'b0;
  logic lineIn, lineDriveLow, fastMode, resetSeen, rxValid, rxBit, bitReq;

  int nChecks = 0, nFail = 0, cyc = 0, relCyc = 0;
  int rxCnt = 0, rstCnt = 0, reqCnt = 0, drvCnt = 0, drvRun = 0, drvDly = 0;
  logic lastRx = 1'b0, drvPrev = 1'b0;

  assign lineIn = !(mLow || lineDriveLow);

  always #2 clk = ~clk;

  sw_slave_front #(.US_CYC(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .lineIn(lineIn), .txEn(txEn), .txBit(txBit),
    .setFast(setFast), .lineDriveLow(lineDriveLow), .fastMode(fastMode),
    .resetSeen(resetSeen), .rxValid(rxValid), .rxBit(rxBit), .bitReq(bitReq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rxValid) begin rxCnt = rxCnt + 1; lastRx = rxBit; end
    if (resetSeen) rstCnt = rstCnt + 1;
    if (bitReq) reqCnt = reqCnt + 1;
    if (lineDriveLow) begin
      if (!drvPrev) begin drvCnt = drvCnt + 1; drvRun = 1; drvDly = cyc - relCyc; end
      else drvRun = drvRun + 1;
    end
    drvPrev = lineDriveLow;
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int len, input logic en, input logic bitv, input int gap);
    @(negedge clk);
    mLow = 1'b1; txEn = en; txBit = bitv;
    repeat (len) @(negedge clk);
    mLow = 1'b0; txEn = 1'b0; relCyc = cyc;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int r0, s0, q0, d0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 drive", lineDriveLow, 0);
    check("R1 fastMode", fastMode, 0);
    // R1 slots before first reset are ignored
    pulse(60, 1'b0, 1'b0, 100);
    check("R1 no rx before reset", rxCnt, 0);
    check("R1 no drive before reset", drvCnt, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      r0 = rxCnt; s0 = rstCnt; q0 = reqCnt; d0 = drvCnt;
      if (v.setf) begin
        @(negedge clk); setFast = 1'b1;
        @(negedge clk); setFast = 1'b0;
        check({tag, " fast pending"}, fastMode, 0);
      end
      pulse(v.lowLen, v.txEn, v.txBit, 250);
      check({tag, " rx count"}, rxCnt - r0, (v.expRx == 2'd2) ? 0 : 1);
      if (v.expRx != 2'd2) check({tag, " rx bit"}, lastRx, v.expRx[0]);
      check({tag, " reset strobe"}, rstCnt - s0, v.expPres);
      check({tag, " bitReq"}, reqCnt - q0, v.txEn);
      check({tag, " drive pulses"}, drvCnt - d0, (v.expDrv != 0) ? 1 : 0);
      if (v.expDrv != 0) check({tag, " drive length"}, drvRun, v.expDrv);
      if (v.expPres) check({tag, " presence delay"}, drvDly, v.expFast ? PDH_F + 1 : PDH_S + 1);
      check({tag, " fastMode"}, fastMode, v.expFast);
    end

    // R7: a low starting inside the recovery window is not a slot
    r0 = rxCnt;
    pulse(60, 1'b0, 1'b0, 2);
    pulse(6, 1'b0, 1'b0, 50);
    check("R7 early fall ignored", rxCnt - r0, 1);
    check("R7 bit of first slot", lastRx, 0);
    pulse(6, 1'b0, 1'b0, 50);
    check("R7 next slot decoded", rxCnt - r0, 2);
    check("R7 next slot bit", lastRx, 1);

    // R9: request waits for a slot end
    @(negedge clk); setFast = 1'b1;
    @(negedge clk); setFast = 1'b0;
    repeat (40) @(negedge clk);
    check("R9 idle keeps std", fastMode, 0);
    pulse(6, 1'b0, 1'b0, 50);
    check("R9 fast after slot", fastMode, 1);

    // R3 R10 fast presence after a fast-window reset
    d0 = drvCnt;
    pulse(50, 1'b0, 1'b0, 100);
    check("R3 fast presence count", drvCnt - d0, 1);
    check("R3 fast presence length", drvRun, PDL_F);
    check("R10 fast kept", fastMode, 1);
    // R2 long reset clears fast
    pulse(480, 1'b0, 1'b0, 250);
    check("R2 cleared at 480", fastMode, 0);
    check("R3 std presence length", drvRun, PDL_S);

    finish_run();
  end

endmodule